// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits between the register bus and the serial shifter of an SPI controller. It holds two word queues: the transmit queue is filled by bus writes and drained by the shifter, and the receive queue is filled by the shifter and drained by bus reads. Each queue holds `DEPTH` words of `WIDTH` bits. `DEPTH` is 32 or 64. From the queue occupancy and from bad accesses, the block builds a 5-bit status word, five raw interrupt causes, their masked copy and a single interrupt line. It also drives the transmit and receive DMA request lines. Thresholds, DMA watermarks, the DMA enable pair and the interrupt mask are plain inputs held by the surrounding register file.

A two-state controller follows the `enable` input. In state OFF the queues are held empty and every push and pop is ignored. The **arm** transition (OFF to ON) is taken at the first clock edge that sees `enable` high. The **flush** transition (ON to OFF) is taken at the first clock edge that sees `enable` low, and that same edge empties both queues. Three interrupt causes are sticky: transmit overflow, receive underflow and receive overflow. A pulse on `clr_wr` with a 4-bit clear code removes them. The other two causes follow the queue levels directly.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: After reset `status` is 5'b01100, `raw_irq` is 5'b00001 when `rx_thresh` is nonzero and `tx_thresh` is 0, both levels are 0, and `irq_out`, `dma_tx_req` and `dma_rx_req` are 0.
- R2: Each queue returns words in the order they were pushed. Its level port rises by one after each accepted push and falls by one after each accepted pop. A level change is visible after the clock edge that takes the access. The transmit and receive data outputs always show the oldest word.
- R3: The bits of `status` are: bit0 busy, which is `busy_in` or a non-empty transmit queue, and is forced low in state OFF; bit1 transmit queue full; bit2 transmit queue empty; bit3 receive queue empty; bit4 receive queue full.
- R4: A bus write to a full transmit queue leaves the queue unchanged and sets sticky cause bit1 of `raw_irq` (transmit overflow).
- R5: A bus read of an empty receive queue returns zero and sets sticky cause bit2 (receive underflow). A shifter pop of an empty transmit queue returns zero and sets no cause.
- R6: A shifter push into a full receive queue is dropped and sets sticky cause bit3 (receive overflow).
- R7: Cause bit0 is high while the transmit level is at or below `tx_thresh`. Cause bit4 is high while the receive level is strictly greater than `rx_thresh`.
- R8: `irq_stat` equals `raw_irq` ANDed bitwise with `irq_mask`, and `irq_out` is high exactly when any bit of `irq_stat` is high.
- R9: On `clr_wr`, code bit0 clears all three sticky causes, bit1 clears receive underflow, bit2 clears receive overflow and bit3 clears transmit overflow. A new event in the same cycle as its clear leaves the cause set.
- R10: `dma_tx_req` is high in state ON while `dma_ctrl[1]` is set and the transmit level is at or below `dma_tx_wm`. `dma_rx_req` is high in state ON while `dma_ctrl[0]` is set and the receive level is strictly above `dma_rx_wm`.
- R11: The clock edge that sees `enable` low empties both queues and leaves the sticky causes unchanged. While OFF, and in the first cycle after `enable` rises, every push is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; low empties both queues |
| busy_in | input | 1 | Shifter is mid-frame |
| tx_wr_en | input | 1 | Bus push into the transmit queue |
| tx_wr_data | input | WIDTH | Word to push into the transmit queue |
| tx_rd_en | input | 1 | Shifter pop from the transmit queue |
| tx_rd_data | output | WIDTH | Oldest transmit word, zero when empty |
| rx_wr_en | input | 1 | Shifter push into the receive queue |
| rx_wr_data | input | WIDTH | Word to push into the receive queue |
| rx_rd_en | input | 1 | Bus pop from the receive queue |
| rx_rd_data | output | WIDTH | Oldest receive word, zero when empty |
| tx_thresh | input | LVL_W | Transmit-empty interrupt threshold |
| rx_thresh | input | LVL_W | Receive-full interrupt threshold |
| dma_tx_wm | input | LVL_W | Transmit DMA watermark |
| dma_rx_wm | input | LVL_W | Receive DMA watermark |
| dma_ctrl | input | 2 | bit0 receive DMA enable, bit1 transmit DMA enable |
| irq_mask | input | 5 | Interrupt mask, same bit order as raw_irq |
| clr_wr | input | 1 | Clear strobe |
| clr_data | input | 4 | Clear code |
| tx_level | output | LVL_W | Transmit queue occupancy |
| rx_level | output | LVL_W | Receive queue occupancy |
| status | output | 5 | Status word |
| raw_irq | output | 5 | Raw interrupt causes |
| irq_stat | output | 5 | Masked interrupt causes |
| irq_out | output | 1 | Combined interrupt line |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The bench builds the block with `DEPTH` = 32 and `WIDTH` = 16, so `LVL_W` is 6. The shallow queue lets a directed test fill either queue to full in 32 cycles and then push one word more. That puts the full flags, both overflow paths, the dropped word and the wrap of the read and write pointers within easy reach. The same setting places the strict-versus-inclusive threshold and watermark boundaries at small levels, and these are checked on both sides of each boundary.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

    // Controller state
    typedef enum logic [0:0] {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } ctl_state_e;

    // Status word bit positions
    localparam int SB_BUSY = 0;
    localparam int SB_TXF  = 1;
    localparam int SB_TXE  = 2;
    localparam int SB_RXE  = 3;
    localparam int SB_RXF  = 4;

    // Interrupt cause bit positions
    localparam int IC_TXE = 0;
    localparam int IC_TXO = 1;
    localparam int IC_RXU = 2;
    localparam int IC_RXO = 3;
    localparam int IC_RXF = 4;
    localparam int IC_N   = 5;

    // Clear code bit positions
    localparam int CC_ALL = 0;
    localparam int CC_RXU = 1;
    localparam int CC_RXO = 2;
    localparam int CC_TXO = 3;

    // DMA enable bit positions
    localparam int DE_RX = 0;
    localparam int DE_TX = 1;

endpackage

// File: rtl/sfu_fifo.sv
module sfu_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             push_ok;
    logic             pop_ok;

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;

    // Show-ahead output, zero when nothing is held
    assign pop_data = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            unique case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/sfu_irq.sv
module sfu_irq
    import sfu_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_txo,
    input  logic             ev_rxu,
    input  logic             ev_rxo,
    input  logic             clr_wr,
    input  logic [3:0]       clr_data,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_thresh,
    input  logic [LVL_W-1:0] rx_thresh,
    input  logic [IC_N-1:0]  irq_mask,
    output logic [IC_N-1:0]  raw_irq,
    output logic [IC_N-1:0]  irq_stat
);

    logic sticky_txo;
    logic sticky_rxu;
    logic sticky_rxo;
    logic wipe_txo;
    logic wipe_rxu;
    logic wipe_rxo;

    always_comb begin
        wipe_txo = clr_wr && (clr_data[CC_ALL] || clr_data[CC_TXO]);
        wipe_rxu = clr_wr && (clr_data[CC_ALL] || clr_data[CC_RXU]);
        wipe_rxo = clr_wr && (clr_data[CC_ALL] || clr_data[CC_RXO]);
    end

    // A new event wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky_txo <= 1'b0;
            sticky_rxu <= 1'b0;
            sticky_rxo <= 1'b0;
        end else begin
            sticky_txo <= ev_txo || (sticky_txo && !wipe_txo);
            sticky_rxu <= ev_rxu || (sticky_rxu && !wipe_rxu);
            sticky_rxo <= ev_rxo || (sticky_rxo && !wipe_rxo);
        end
    end

    always_comb begin
        raw_irq         = '0;
        raw_irq[IC_TXE] = (tx_level <= tx_thresh);
        raw_irq[IC_TXO] = sticky_txo;
        raw_irq[IC_RXU] = sticky_rxu;
        raw_irq[IC_RXO] = sticky_rxo;
        raw_irq[IC_RXF] = (rx_level > rx_thresh);
        irq_stat        = raw_irq & irq_mask;
    end

endmodule

// File: rtl/sfu_dma.sv
module sfu_dma
    import sfu_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             active,
    input  logic [1:0]       dma_ctrl,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_wm,
    input  logic [LVL_W-1:0] rx_wm,
    output logic             tx_req,
    output logic             rx_req
);

    always_comb begin
        tx_req = active && dma_ctrl[DE_TX] && (tx_level <= tx_wm);
        rx_req = active && dma_ctrl[DE_RX] && (rx_level > rx_wm);
    end

endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
    import sfu_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DEPTH = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             busy_in,
    input  logic             tx_wr_en,
    input  logic [WIDTH-1:0] tx_wr_data,
    input  logic             tx_rd_en,
    output logic [WIDTH-1:0] tx_rd_data,
    input  logic             rx_wr_en,
    input  logic [WIDTH-1:0] rx_wr_data,
    input  logic             rx_rd_en,
    output logic [WIDTH-1:0] rx_rd_data,
    input  logic [LVL_W-1:0] tx_thresh,
    input  logic [LVL_W-1:0] rx_thresh,
    input  logic [LVL_W-1:0] dma_tx_wm,
    input  logic [LVL_W-1:0] dma_rx_wm,
    input  logic [1:0]       dma_ctrl,
    input  logic [4:0]       irq_mask,
    input  logic             clr_wr,
    input  logic [3:0]       clr_data,
    output logic [LVL_W-1:0] tx_level,
    output logic [LVL_W-1:0] rx_level,
    output logic [4:0]       status,
    output logic [4:0]       raw_irq,
    output logic [4:0]       irq_stat,
    output logic             irq_out,
    output logic             dma_tx_req,
    output logic             dma_rx_req
);

    ctl_state_e state_q;
    ctl_state_e state_d;
    logic       go;
    logic       flush;
    logic       tx_full;
    logic       tx_empty;
    logic       rx_full;
    logic       rx_empty;
    logic       ev_txo;
    logic       ev_rxu;
    logic       ev_rxo;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: arm on enable, flush on its removal
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  state_d = enable ? ST_ON : ST_OFF;
            ST_ON:   state_d = enable ? ST_ON : ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    // State outputs
    always_comb begin
        go = 1'b0;
        unique case (state_q)
            ST_OFF:  go = 1'b0;
            ST_ON:   go = enable;
            default: go = 1'b0;
        endcase
        flush = !go;
    end

    sfu_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (tx_wr_en),
        .push_data (tx_wr_data),
        .pop       (tx_rd_en),
        .pop_data  (tx_rd_data),
        .level     (tx_level),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    sfu_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (rx_wr_en),
        .push_data (rx_wr_data),
        .pop       (rx_rd_en),
        .pop_data  (rx_rd_data),
        .level     (rx_level),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    // Bad-access events, only counted while running
    always_comb begin
        ev_txo = go && tx_wr_en && tx_full;
        ev_rxu = go && rx_rd_en && rx_empty;
        ev_rxo = go && rx_wr_en && rx_full;
    end

    always_comb begin
        status          = '0;
        status[SB_BUSY] = go && (busy_in || !tx_empty);
        status[SB_TXF]  = tx_full;
        status[SB_TXE]  = tx_empty;
        status[SB_RXE]  = rx_empty;
        status[SB_RXF]  = rx_full;
    end

    sfu_irq #(.LVL_W(LVL_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_txo    (ev_txo),
        .ev_rxu    (ev_rxu),
        .ev_rxo    (ev_rxo),
        .clr_wr    (clr_wr),
        .clr_data  (clr_data),
        .tx_level  (tx_level),
        .rx_level  (rx_level),
        .tx_thresh (tx_thresh),
        .rx_thresh (rx_thresh),
        .irq_mask  (irq_mask),
        .raw_irq   (raw_irq),
        .irq_stat  (irq_stat)
    );

    assign irq_out = |irq_stat;

    sfu_dma #(.LVL_W(LVL_W)) u_dma (
        .active   (go),
        .dma_ctrl (dma_ctrl),
        .tx_level (tx_level),
        .rx_level (rx_level),
        .tx_wm    (dma_tx_wm),
        .rx_wm    (dma_rx_wm),
        .tx_req   (dma_tx_req),
        .rx_req   (dma_rx_req)
    );

endmodule

// File: rtl/sfu_chk.sv
module sfu_chk #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             tx_wr_en,
    input logic             rx_wr_en,
    input logic             rx_rd_en,
    input logic [WIDTH-1:0] rx_rd_data,
    input logic [1:0]       dma_ctrl,
    input logic             clr_wr,
    input logic [3:0]       clr_data,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic [4:0]       status,
    input logic [4:0]       raw_irq,
    input logic             dma_tx_req
);

    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= LVL_W'(DEPTH)) && (rx_level <= LVL_W'(DEPTH)));

    // R3
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status[2:1]) && $onehot0(status[4:3]));

    // R4
    tx_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && status[1] && tx_wr_en) |=> (raw_irq[1] && $stable(tx_level)));

    // R5
    rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3] && rx_rd_en) |-> (rx_rd_data == '0));

    // R6
    rx_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && status[4] && rx_wr_en && !rx_rd_en) |=> raw_irq[3]);

    // R9
    clear_txo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_data[3] && !tx_wr_en) |=> !raw_irq[1]);

    // R9
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_data[0] && !tx_wr_en && !rx_wr_en && !rx_rd_en)
        |=> (raw_irq[3:1] == 3'b000));

    // R10
    dma_tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_tx_req |-> (dma_ctrl[1] && enable));

    // R11
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ((tx_level == '0) && (rx_level == '0)));

endmodule

bind spi_fifo_irq_unit sfu_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_sfu_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .tx_wr_en   (tx_wr_en),
    .rx_wr_en   (rx_wr_en),
    .rx_rd_en   (rx_rd_en),
    .rx_rd_data (rx_rd_data),
    .dma_ctrl   (dma_ctrl),
    .clr_wr     (clr_wr),
    .clr_data   (clr_data),
    .tx_level   (tx_level),
    .rx_level   (rx_level),
    .status     (status),
    .raw_irq    (raw_irq),
    .dma_tx_req (dma_tx_req)
);

// File: tb/tb_spi_fifo_irq_unit.sv
`timescale 1ns/1ps
module tb_spi_fifo_irq_unit;

    localparam int WIDTH = 16;
    localparam int DEPTH = 32;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             busy_in = 1'b0;
    logic             tx_wr_en = 1'b0;
    logic [WIDTH-1:0] tx_wr_data = '0;
    logic             tx_rd_en = 1'b0;
    logic [WIDTH-1:0] tx_rd_data;
    logic             rx_wr_en = 1'b0;
    logic [WIDTH-1:0] rx_wr_data = '0;
    logic             rx_rd_en = 1'b0;
    logic [WIDTH-1:0] rx_rd_data;
    logic [LVL_W-1:0] tx_thresh = '0;
    logic [LVL_W-1:0] rx_thresh = LVL_W'(3);
    logic [LVL_W-1:0] dma_tx_wm = '0;
    logic [LVL_W-1:0] dma_rx_wm = '0;
    logic [1:0]       dma_ctrl = '0;
    logic [4:0]       irq_mask = '0;
    logic             clr_wr = 1'b0;
    logic [3:0]       clr_data = '0;
    logic [LVL_W-1:0] tx_level;
    logic [LVL_W-1:0] rx_level;
    logic [4:0]       status;
    logic [4:0]       raw_irq;
    logic [4:0]       irq_stat;
    logic             irq_out;
    logic             dma_tx_req;
    logic             dma_rx_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    spi_fifo_irq_unit #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .busy_in(busy_in),
        .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
        .tx_rd_en(tx_rd_en), .tx_rd_data(tx_rd_data),
        .rx_wr_en(rx_wr_en), .rx_wr_data(rx_wr_data),
        .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
        .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
        .dma_tx_wm(dma_tx_wm), .dma_rx_wm(dma_rx_wm), .dma_ctrl(dma_ctrl),
        .irq_mask(irq_mask), .clr_wr(clr_wr), .clr_data(clr_data),
        .tx_level(tx_level), .rx_level(rx_level), .status(status),
        .raw_irq(raw_irq), .irq_stat(irq_stat), .irq_out(irq_out),
        .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Each access task starts and ends at a falling edge
    task automatic push_tx(input logic [WIDTH-1:0] d);
        tx_wr_en = 1'b1; tx_wr_data = d;
        @(negedge clk);
        tx_wr_en = 1'b0;
    endtask

    task automatic push_rx(input logic [WIDTH-1:0] d);
        rx_wr_en = 1'b1; rx_wr_data = d;
        @(negedge clk);
        rx_wr_en = 1'b0;
    endtask

    task automatic pop_tx(output logic [WIDTH-1:0] d);
        tx_rd_en = 1'b1;
        #1 d = tx_rd_data;
        @(negedge clk);
        tx_rd_en = 1'b0;
    endtask

    task automatic pop_rx(output logic [WIDTH-1:0] d);
        rx_rd_en = 1'b1;
        #1 d = rx_rd_data;
        @(negedge clk);
        rx_rd_en = 1'b0;
    endtask

    task automatic clear(input logic [3:0] code);
        clr_wr = 1'b1; clr_data = code;
        @(negedge clk);
        clr_wr = 1'b0; clr_data = '0;
    endtask

    task automatic t_reset();
        chk("R1 status", status, 5'b01100);
        chk("R1 raw_irq", raw_irq, 5'b00001);
        chk("R1 tx_level", tx_level, 0);
        chk("R1 rx_level", rx_level, 0);
        chk("R1 irq_out", irq_out, 0);
        chk("R1 dma reqs", {dma_tx_req, dma_rx_req}, 2'b00);
    endtask

    task automatic t_busy();
        busy_in = 1'b1;
        #1 chk("R3 busy from shifter", status[0], 1);
        busy_in = 1'b0;
        #1 chk("R3 idle busy low", status[0], 0);
        @(negedge clk);
    endtask

    task automatic t_tx_fill();
        logic [WIDTH-1:0] d;
        for (int i = 0; i < DEPTH; i++) push_tx(16'hA000 + 16'(i));
        chk("R2 tx level full", tx_level, DEPTH);
        chk("R3 status tx full/busy", status, 5'b01011);
        chk("R7 tx-empty cause low", raw_irq[0], 0);
        push_tx(16'hBEEF);
        chk("R4 overflow level kept", tx_level, DEPTH);
        chk("R4 overflow cause", raw_irq, 5'b00010);
        for (int i = 0; i < DEPTH; i++) begin
            pop_tx(d);
            chk("R2 tx order", d, 16'hA000 + 16'(i));
        end
        chk("R2 tx level drained", tx_level, 0);
        pop_tx(d);
        chk("R5 tx empty pop zero", d, 0);
        chk("R5 tx empty pop no cause", raw_irq, 5'b00011);
    endtask

    task automatic t_set_wins();
        logic [WIDTH-1:0] d;
        clear(4'b1000);
        chk("R9 clear txo", raw_irq[1], 0);
        for (int i = 0; i < DEPTH; i++) push_tx(16'h1111);
        clr_wr = 1'b1; clr_data = 4'b1000;
        push_tx(16'h2222);
        clr_wr = 1'b0; clr_data = '0;
        chk("R9 set wins over clear", raw_irq[1], 1);
        for (int i = 0; i < DEPTH; i++) pop_tx(d);
        clear(4'b0001);
        chk("R9 clear all", raw_irq, 5'b00001);
    endtask

    task automatic t_rx();
        logic [WIDTH-1:0] d;
        for (int i = 0; i < 3; i++) push_rx(16'h5000 + 16'(i));
        chk("R7 rx level 3 not above thresh", raw_irq[4], 0);
        push_rx(16'h5003);
        chk("R7 rx level 4 above thresh", raw_irq[4], 1);
        chk("R2 rx level", rx_level, 4);
        for (int i = 0; i < 4; i++) begin
            pop_rx(d);
            chk("R2 rx order", d, 16'h5000 + 16'(i));
        end
        pop_rx(d);
        chk("R5 rx empty read zero", d, 0);
        chk("R5 underflow cause", raw_irq[2], 1);
        chk("R5 rx level stays 0", rx_level, 0);
        for (int i = 0; i <= DEPTH; i++) push_rx(16'h6000 + 16'(i));
        chk("R6 rx level capped", rx_level, DEPTH);
        chk("R6 overflow cause", raw_irq[3], 1);
        chk("R3 rx full flag", status[4:3], 2'b10);
        pop_rx(d);
        chk("R6 dropped word absent, oldest first", d, 16'h6000);
        chk("R7 raw causes", raw_irq, 5'b11101);
    endtask

    task automatic t_mask();
        irq_mask = 5'b01010;
        #1 chk("R8 masked pick", irq_stat, 5'b01000);
        chk("R8 line high", irq_out, 1);
        irq_mask = 5'b00010;
        #1 chk("R8 masked none", irq_stat, 5'b00000);
        chk("R8 line low", irq_out, 0);
        irq_mask = 5'b11111;
        #1 chk("R8 masked all", irq_stat, 5'b11101);
        irq_mask = 5'b00000;
        @(negedge clk);
    endtask

    task automatic t_clear_sel();
        clear(4'b0100);
        chk("R9 clear rx overflow only", raw_irq, 5'b10101);
        clear(4'b0010);
        chk("R9 clear rx underflow only", raw_irq, 5'b10001);
    endtask

    task automatic t_dma();
        dma_ctrl = 2'b01; dma_rx_wm = LVL_W'(30);
        #1 chk("R10 rx req above wm", dma_rx_req, 1);
        chk("R10 tx req disabled", dma_tx_req, 0);
        dma_rx_wm = LVL_W'(31);
        #1 chk("R10 rx req at wm low", dma_rx_req, 0);
        dma_ctrl = 2'b10; dma_tx_wm = '0;
        #1 chk("R10 tx req at wm", dma_tx_req, 1);
        chk("R10 rx req disabled", dma_rx_req, 0);
        @(negedge clk);
        push_tx(16'h7777);
        chk("R10 tx req above wm", dma_tx_req, 0);
        dma_tx_wm = LVL_W'(1);
        #1 chk("R10 tx req raised wm", dma_tx_req, 1);
        dma_ctrl = 2'b00;
        #1 chk("R10 both off", {dma_tx_req, dma_rx_req}, 2'b00);
        @(negedge clk);
    endtask

    task automatic t_flush();
        push_rx(16'h0001);
        push_rx(16'h0002);
        chk("R6 overflow again", raw_irq[3], 1);
        dma_ctrl = 2'b10;
        enable = 1'b0;
        @(negedge clk);
        chk("R11 levels flushed", {tx_level, rx_level}, 0);
        chk("R11 sticky kept", raw_irq[3], 1);
        chk("R11 status after flush", status, 5'b01100);
        chk("R10 no tx req while off", dma_tx_req, 0);
        push_tx(16'h3333);
        push_rx(16'h4444);
        chk("R11 pushes ignored while off", {tx_level, rx_level}, 0);
        busy_in = 1'b1;
        #1 chk("R3 busy low while off", status[0], 0);
        busy_in = 1'b0;
        dma_ctrl = 2'b00;
        enable = 1'b1;
        push_tx(16'h5555);
        chk("R11 push in arm cycle ignored", tx_level, 0);
        push_tx(16'h6666);
        chk("R11 push after arm taken", tx_level, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        enable = 1'b1;
        @(negedge clk);
        t_busy();
        t_tx_fill();
        t_set_wins();
        t_rx();
        t_mask();
        t_clear_sel();
        t_dma();
        t_flush();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule